// File: doc/BRIEF.md
# Sequential Byte Readout Port

This block lets an external programmer read a byte memory without an address bus. An internal address counter picks one byte of the array. The host sets the counter to zero with a pulse on a clear pin and moves it forward one location with each rising edge on a step pin. While the host holds an active-low output-enable pin low, the byte at the current location is driven on an 8-bit data port. While that pin is high, the port floats.

All three host pins are asynchronous to the block. Each one passes through a synchroniser running on a faster system clock. The clear and step pins then go through a rising-edge detector, so one pin pulse gives exactly one counter action however long the pulse lasts.

Only sequential access is possible. To reach a location below the current one, the host clears the counter and steps forward again. The array is filled through a plain synchronous load port, which the testbench uses to set up known contents.

Top module: `seq_byte_reader`

## Requirements
- R1: After reset the counter holds location 0, `dq_oe` is 0 and `dq_out` is 0.
- R2: A rising edge on `clr_pin` sets the counter to location 0, whatever its previous value.
- R3: Each rising edge on `step_pin` adds exactly one to the counter, however long the pin stays high. The counter does not change without a pin edge.
- R4: While `oe_n_pin` is low, `dq_oe` is 1 and `dq_out` carries the byte at the current location. While `oe_n_pin` is high, `dq_oe` is 0 and `dq_out` is 0.
- R5: `dq_out[n]` equals stored data bit n for n = 0..7, with no reordering. A stored 1 is read as 1 and a stored 0 as 0: stored 8'h80 reads as 8'h80, and 8'h01 reads as 8'h01.
- R6: The counter is 12 bits wide. Stepping from location 4095 gives location 0.
- R7: If clear and step edges are detected in the same system-clock cycle, the counter ends at 0, not at 1.
- R8: A location below the current one can be read after a clear followed by the matching number of step pulses.
- R9: A write on the load port (`load_we` high at a clock edge) stores `load_data` at `load_addr`, and a later readout of that location returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any host pin activity |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_pin | input | 1 | Asynchronous host pin; a rising edge sets the counter to zero |
| step_pin | input | 1 | Asynchronous host pin; a rising edge advances the counter |
| oe_n_pin | input | 1 | Asynchronous host pin; low requests the current byte |
| load_we | input | 1 | Array load strobe |
| load_addr | input | 12 | Array load location |
| load_data | input | 8 | Array load byte |
| dq_out | output | 8 | Read byte, zero while not driven |
| dq_oe | output | 1 | Drive enable for the data port (1 = driven, 0 = high impedance) |

## Verification
The clear and the step action can land in the same system-clock cycle. Clear must win there, otherwise the counter would end at location 1. The bench provokes this by raising both host pins on the same clock edge. Both pins pass through identical synchroniser depths, so their detected edges coincide. The bench then reads the port and expects the byte stored at location 0, which differs from the byte at location 1.

// File: rtl/smr_pkg.sv
// Package: shared constants for the sequential byte readout port.
// Assumes host pins are indexed in the order listed below.
package smr_pkg;
    localparam int unsigned PIN_CLR  = 0;
    localparam int unsigned PIN_STEP = 1;
    localparam int unsigned PIN_OE_N = 2;
    localparam int unsigned NUM_PINS = 3;
    // Idle (reset) level of each pin: output enable idles high.
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/smr_pin_sync.sv
// Module: multi-bit synchroniser with rising-edge detect.
// Each input bit passes through STAGES flops plus one history flop.
// Assumes input pulses last longer than STAGES+1 system clock cycles.
module smr_pin_sync #(
    parameter int unsigned         N      = 3,
    parameter int unsigned         STAGES = 2,
    parameter logic [N-1:0]        IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    localparam int unsigned CHAIN = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [CHAIN-1:0] chain_q;

        // Shift the pin into its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {CHAIN{IDLE[i]}};
            else        chain_q <= {chain_q[CHAIN-2:0], pins_in[i]};
        end

        assign level[i] = chain_q[STAGES-1];
        assign rise[i]  = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/smr_addr_ctr.sv
// Module: wrapping address counter with clear and advance.
// Clear has priority over advance when both occur in one cycle.
module smr_addr_ctr #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    // Update the location pointer; natural binary wrap at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (adv) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/smr_byte_array.sv
// Module: byte array with one synchronous write port and a registered read.
// Depth is 2**ADDR_W. Read data lags the read address by one cycle.
module smr_byte_array #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Store a loaded byte.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Register the byte at the current read location.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= store[raddr];
    end
endmodule

// File: rtl/seq_byte_reader.sv
// Module: top of the sequential byte readout port.
// Host pins are asynchronous; they are synchronised and edge-detected here.
// The data port is modelled as data plus a separate drive enable.
module seq_byte_reader #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_pin,
    input  logic              step_pin,
    input  logic              oe_n_pin,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    import smr_pkg::*;

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_lvl;
    logic [NUM_PINS-1:0] pins_rise;
    logic                clr_evt;
    logic                step_evt;
    logic                oe_lvl;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   rd_byte;

    // Gather host pins in package order.
    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CLR]  = clr_pin;
        pins_raw[PIN_STEP] = step_pin;
        pins_raw[PIN_OE_N] = oe_n_pin;
    end

    smr_pin_sync #(
        .N      (NUM_PINS),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_raw),
        .level   (pins_lvl),
        .rise    (pins_rise)
    );

    assign clr_evt  = pins_rise[PIN_CLR];
    assign step_evt = pins_rise[PIN_STEP];
    assign oe_lvl   = pins_lvl[PIN_OE_N];

    smr_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_evt),
        .adv   (step_evt),
        .addr  (addr)
    );

    smr_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (addr),
        .rdata (rd_byte)
    );

    // Drive the port only while output enable is low; bits pass straight through.
    always_comb begin
        dq_oe  = ~oe_lvl;
        dq_out = dq_oe ? rd_byte : '0;
    end
endmodule

// File: rtl/seq_byte_reader_chk.sv
// Checker: temporal properties of the sequential byte readout port.
// Attached to every seq_byte_reader instance by the bind below.
module seq_byte_reader_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_evt,
    input logic              step_evt,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out
);
    a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> addr == '0);

    a_r7_clear_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && step_evt) |=> addr == '0);

    // R3 and R6: a lone step adds one, with wrap at the top.
    a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && !clr_evt) |=> addr == ADDR_W'($past(addr) + 1'b1));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_evt && !clr_evt) |=> $stable(addr));

    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt |=> !step_evt);

    a_r4_float_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == '0);
endmodule

bind seq_byte_reader seq_byte_reader_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_evt  (clr_evt),
    .step_evt (step_evt),
    .addr     (addr),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out)
);

// File: tb/seq_byte_reader_tb_top.sv
module seq_byte_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC = 8;
    // Vector: {clear first, step count, expected location}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 12'd0,  12'd0},
        {1'b0, 12'd5,  12'd5},
        {1'b0, 12'd1,  12'd6},
        {1'b1, 12'd3,  12'd3},
        {1'b1, 12'd0,  12'd0},
        {1'b0, 12'd17, 12'd17},
        {1'b1, 12'd9,  12'd9},
        {1'b0, 12'd2,  12'd11}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_pin = 1'b0;
    logic          step_pin = 1'b0;
    logic          oe_n_pin = 1'b1;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_byte_reader dut_i (
        .clk(clk), .rst_n(rst_n), .clr_pin(clr_pin), .step_pin(step_pin),
        .oe_n_pin(oe_n_pin), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_step(input int hold);
        step_pin = 1'b1; idle(hold);
        step_pin = 1'b0; idle(3);
    endtask

    task automatic pulse_clear();
        clr_pin = 1'b1; idle(3);
        clr_pin = 1'b0; idle(3);
    endtask

    // Lower output enable, sample {dq_oe, dq_out}, raise it again.
    task automatic read_port(output logic [DW:0] v);
        oe_n_pin = 1'b0; idle(6);
        v = {dq_oe, dq_out};
        oe_n_pin = 1'b1; idle(4);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        load_we = 1'b1; load_addr = a; load_data = d;
        idle(1);
        load_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW:0] v;
        idle(4);
        // R1: reset state of the port
        check("R1 reset", {dq_oe, dq_out}, 9'h000);
        rst_n = 1'b1;
        idle(2);
        check("R1 port idle after reset", {dq_oe, dq_out}, 9'h000);
        for (int a = 0; a < DEPTH; a++) load(AW'(a), pat(AW'(a)));
        idle(2);
        read_port(v);
        check("R1 counter at 0 / R9 load", v, {1'b1, pat(12'd0)});

        // R2 R3 R8: vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) pulse_clear();
            for (int s = 0; s < int'(VEC[i][23:12]); s++) pulse_step(3);
            read_port(v);
            check("R8 R2 R3 vector", v, {1'b1, pat(VEC[i][11:0])});
        end

        // R4 R5: full sequential readout, then R6 wrap
        pulse_clear();
        for (int a = 0; a < DEPTH; a++) begin
            read_port(v);
            check("R4 sequential read", v, {1'b1, pat(AW'(a))});
            pulse_step(3);
        end
        read_port(v);
        check("R6 wrap to 0", v, {1'b1, pat(12'd0)});

        // R4: port floats with output enable high
        idle(4);
        check("R4 float", {dq_oe, dq_out}, 9'h000);

        // R3: long step pulse advances once
        pulse_clear();
        pulse_step(25);
        read_port(v);
        check("R3 long pulse single step", v, {1'b1, pat(12'd1)});

        // R7: clear and step edges in the same cycle
        pulse_step(3); pulse_step(3); pulse_step(3);
        clr_pin = 1'b1; step_pin = 1'b1; idle(3);
        clr_pin = 1'b0; step_pin = 1'b0; idle(3);
        read_port(v);
        check("R7 clear wins", v, {1'b1, pat(12'd0)});

        // R5 R9: bit mapping through reloaded bytes
        load(12'd2, 8'h80);
        load(12'd3, 8'h01);
        pulse_clear();
        pulse_step(3); pulse_step(3);
        read_port(v);
        check("R5 bit 7 only", v, 9'h180);
        pulse_step(3);
        read_port(v);
        check("R5 bit 0 only", v, 9'h101);

        // R2: clear from a nonzero location
        pulse_clear();
        read_port(v);
        check("R2 clear to 0", v, {1'b1, pat(12'd0)});

        summary();
        $finish;
    end
endmodule